// File: doc/BRIEF.md
# Register-Write Breakpoint Match Unit

This unit sits beside a CPU core's execution stage and decides when to stop the core for debugging. It holds six 16-bit breakpoint registers. A host debug link writes and reads them in background mode, and the CPU has no path to them. The unit watches each executed instruction: its register destination (module and index), the value it writes, the data-memory address it touches, and whether it activates the prefix register. It raises a one-cycle break request toward the debug engine when an enabled breakpoint matches.

Breakpoints 0 to 3 are storage only here, because their instruction-address and data-address comparators live elsewhere. Breakpoints 4 and 5 have two roles, chosen by a mode input. In address role, each compares its whole value with the data-memory address. In register role, each compares a module/index destination and a masked data pattern. A match on a prefixing instruction is held back until the prefixed instruction completes. After a request has fired, the unit stays silent until the debug engine acknowledges entry.

Top module: `regwr_break_unit`

## Requirements
- R1: After power-on reset (`rst_n` low), every breakpoint register reads 16'hFFFF and `brk_req` is 0.
- R2: A cycle with `tlr_i` high sets every breakpoint register to 16'hFFFF at the next clock edge. This takes priority over a host write in the same cycle.
- R3: A host write (`host_wr_en`, `host_addr` 0 to 5) updates that register at the next edge. `host_rdata` shows register `host_addr` combinationally. Addresses 6 and 7 read 0, and writes to them change nothing.
- R4: When `dbg_en` is 0, `brk_req` stays 0 whatever the instruction stream.
- R5: With `reg_mode`=1, breakpoint 4 or 5 matches an executed instruction (`instr_done` and `wr_valid`) when `wr_module` equals bits [3:0] and `wr_index` equals bits [8:4] of the breakpoint register, and `wr_data` equals `cmp_data` on every bit where `cmp_mask` is 1. Bits [15:9] are ignored. `brk_req` is high in the cycle after the matching instruction.
- R6: When `cmp_mask` is all zeros, a register-role match needs only the destination to agree.
- R7: A register-role destination match whose masked data differs produces no request.
- R8: With `reg_mode`=0, breakpoint 4 or 5 matches when `dmem_valid` is high and `dmem_addr` equals its full 16-bit value. Register writes then cause no match.
- R9: A match on an instruction with `pfx_active`=1 raises no request for that instruction. The request fires in the cycle after the next `instr_done` that has `pfx_active`=0.
- R10: `brk_req` is high for exactly one cycle. No further request fires until `dbg_ack` has been seen.
- R11: A breakpoint compare in the same cycle as a host write to that breakpoint uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tlr_i | input | 1 | Test-logic-reset state entered; presets breakpoints |
| host_wr_en | input | 1 | Host background write strobe |
| host_addr | input | 3 | Breakpoint register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected breakpoint register, 0 when out of range |
| dbg_en | input | 1 | Global breakpoint enable |
| reg_mode | input | 1 | 1: breakpoints 4/5 register role, 0: address role |
| cmp_data | input | 16 | Register-role comparison pattern |
| cmp_mask | input | 16 | Register-role bit mask, 1 = compare |
| instr_done | input | 1 | An instruction completes this cycle |
| wr_valid | input | 1 | The instruction writes a register |
| wr_module | input | 4 | Destination module |
| wr_index | input | 5 | Destination register index |
| wr_data | input | 16 | Value written |
| dmem_valid | input | 1 | The instruction accesses data memory |
| dmem_addr | input | 16 | Data-memory address |
| pfx_active | input | 1 | The instruction activates the prefix register |
| dbg_ack | input | 1 | Debug engine acknowledges entry, re-arms |
| brk_req | output | 1 | One-cycle break request |

## Verification
Two functions can meet in one clock. The first is a host write that reprograms breakpoint 4. The second is a completing instruction whose destination matches the old contents of breakpoint 4 but not the new ones. The bench provokes this collision with a directed case: both happen in the same cycle. It expects a request in the following cycle, and it expects a second instruction aimed at the old destination to stay silent after re-arming. The random phase then issues host writes and matching instructions independently, so such collisions recur. Each outcome is judged against a bench model that applies writes only after comparing.

// File: rtl/regwr_break_unit.sv
module regwr_break_unit #(
  parameter int NUM_BP     = 6,
  parameter int DW         = 16,
  parameter int AW         = 3,
  parameter int MOD_W      = 4,
  parameter int IDX_W      = 5,
  parameter int FIRST_FLEX = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tlr_i,
  input  logic          host_wr_en,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          dbg_en,
  input  logic          reg_mode,
  input  logic [DW-1:0] cmp_data,
  input  logic [DW-1:0] cmp_mask,
  input  logic          instr_done,
  input  logic          wr_valid,
  input  logic [3:0]    wr_module,
  input  logic [4:0]    wr_index,
  input  logic [DW-1:0] wr_data,
  input  logic          dmem_valid,
  input  logic [DW-1:0] dmem_addr,
  input  logic          pfx_active,
  input  logic          dbg_ack,
  output logic          brk_req
);
  localparam int NUM_FLEX = NUM_BP - FIRST_FLEX;
  localparam int IDX_LSB  = MOD_W;
  localparam int IDX_MSB  = MOD_W + IDX_W - 1;

  logic [DW-1:0]       bp_q [NUM_BP];
  logic [NUM_FLEX-1:0] flex_hit;
  logic                data_ok, any_hit, cand, fire;
  logic                pend_q, armed_q, brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_BP; k++) bp_q[k] <= '1;
    end else if (tlr_i) begin
      for (int k = 0; k < NUM_BP; k++) bp_q[k] <= '1;
    end else if (host_wr_en) begin
      for (int k = 0; k < NUM_BP; k++)
        if (host_addr == AW'(k)) bp_q[k] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    for (int k = 0; k < NUM_BP; k++)
      if (host_addr == AW'(k)) host_rdata = bp_q[k];
  end

  assign data_ok = ((wr_data ^ cmp_data) & cmp_mask) == '0;

  for (genvar g = 0; g < NUM_FLEX; g++) begin : g_flex
    logic reg_hit, addr_hit;
    assign reg_hit  = wr_valid && data_ok &&
                      (wr_module == bp_q[FIRST_FLEX+g][MOD_W-1:0]) &&
                      (wr_index  == bp_q[FIRST_FLEX+g][IDX_MSB:IDX_LSB]);
    assign addr_hit = dmem_valid && (dmem_addr == bp_q[FIRST_FLEX+g]);
    assign flex_hit[g] = reg_mode ? reg_hit : addr_hit;
  end

  assign any_hit = |flex_hit;
  assign cand    = dbg_en && armed_q && instr_done && any_hit;
  assign fire    = dbg_en && armed_q && instr_done && !pfx_active && (any_hit || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b1;
      brk_q   <= 1'b0;
    end else begin
      brk_q <= fire;
      if (!dbg_en || fire)         pend_q <= 1'b0;
      else if (cand && pfx_active) pend_q <= 1'b1;
      if (fire)         armed_q <= 1'b0;
      else if (dbg_ack) armed_q <= 1'b1;
    end
  end

  assign brk_req = brk_q;
endmodule

// File: rtl/regwr_break_unit_chk.sv
module regwr_break_unit_chk #(
  parameter int NUM_BP = 6,
  parameter int DW     = 16,
  parameter int AW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tlr_i,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_rdata,
  input logic          dbg_en,
  input logic          instr_done,
  input logic          pfx_active,
  input logic          dbg_ack,
  input logic          brk_req
);
  logic wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= 1'b0;
    else if (dbg_ack) wait_q <= 1'b0;
    else if (brk_req) wait_q <= 1'b1;
  end

  // R10
  brk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);
  // R10
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !wait_q);
  // R4
  brk_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(dbg_en));
  // R9
  brk_after_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(instr_done && !pfx_active));
  // R2
  tlr_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tlr_i) && (int'(host_addr) < NUM_BP)) |-> (host_rdata == '1));
endmodule

bind regwr_break_unit regwr_break_unit_chk #(.NUM_BP(NUM_BP), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tlr_i(tlr_i), .host_addr(host_addr),
  .host_rdata(host_rdata), .dbg_en(dbg_en), .instr_done(instr_done),
  .pfx_active(pfx_active), .dbg_ack(dbg_ack), .brk_req(brk_req)
);

// File: tb/regwr_break_unit_bench.sv
`timescale 1ns/1ps
module regwr_break_unit_bench;
  logic clk = 0, rst_n = 0, tlr_i = 0, host_wr_en = 0;
  logic [2:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic dbg_en = 0, reg_mode = 0;
  logic [15:0] cmp_data = 0, cmp_mask = 0;
  logic instr_done = 0, wr_valid = 0;
  logic [3:0] wr_module = 0;
  logic [4:0] wr_index = 0;
  logic [15:0] wr_data = 0, dmem_addr = 0;
  logic dmem_valid = 0, pfx_active = 0, dbg_ack = 0, brk_req;

  always #2.5 clk = ~clk;

  regwr_break_unit u_regwr_break_unit (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  bit [15:0] m_bp [6];
  bit m_pend, m_armed, m_brk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_hit();
    bit any = 0;
    for (int i = 4; i < 6; i++) begin
      if (reg_mode)
        any |= wr_valid && wr_module == m_bp[i][3:0] && wr_index == m_bp[i][8:4]
               && (((wr_data ^ cmp_data) & cmp_mask) == 16'h0);
      else
        any |= dmem_valid && dmem_addr == m_bp[i];
    end
    return any;
  endfunction

  function automatic logic [15:0] model_rd();
    return (host_addr < 6) ? m_bp[host_addr] : 16'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 6; i++) m_bp[i] = 16'hFFFF;
    m_pend = 0; m_armed = 1; m_brk = 0;
  endtask

  task automatic cycle();
    bit any, cand, fire;
    @(posedge clk);
    any  = model_hit();
    cand = dbg_en && m_armed && instr_done && any;
    fire = dbg_en && m_armed && instr_done && !pfx_active && (any || m_pend);
    m_brk = fire;
    if (!dbg_en || fire) m_pend = 0;
    else if (cand && pfx_active) m_pend = 1;
    if (fire) m_armed = 0;
    else if (dbg_ack) m_armed = 1;
    if (tlr_i) for (int i = 0; i < 6; i++) m_bp[i] = 16'hFFFF;
    else if (host_wr_en && host_addr < 6) m_bp[host_addr] = host_wdata;
    @(negedge clk);
    check("R5 model brk", {15'h0, brk_req}, {15'h0, m_brk});
    check("R3 model rdata", host_rdata, model_rd());
  endtask

  task automatic idle();
    instr_done = 0; wr_valid = 0; dmem_valid = 0; pfx_active = 0;
    host_wr_en = 0; dbg_ack = 0; tlr_i = 0;
  endtask

  task automatic hwrite(int a, logic [15:0] v);
    host_wr_en = 1; host_addr = 3'(a); host_wdata = v;
    cycle(); host_wr_en = 0;
  endtask

  task automatic instr(logic [3:0] m, logic [4:0] x, logic [15:0] d, bit pfx);
    instr_done = 1; wr_valid = 1; wr_module = m; wr_index = x; wr_data = d;
    pfx_active = pfx;
    cycle(); idle();
  endtask

  task automatic ack();
    dbg_ack = 1; cycle(); dbg_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 brk after reset", {15'h0, brk_req}, 16'h0);
    for (int a = 0; a < 8; a++) begin
      host_addr = 3'(a); #0.1;
      check("R1 reset value", host_rdata, a < 6 ? 16'hFFFF : 16'h0);
    end
    for (int a = 0; a < 6; a++) hwrite(a, 16'h1100 + 16'(a));
    hwrite(6, 16'hDEAD);
    hwrite(7, 16'hBEEF);
    for (int a = 0; a < 8; a++) begin
      host_addr = 3'(a); #0.1;
      check("R3 readback", host_rdata, a < 6 ? 16'h1100 + 16'(a) : 16'h0);
    end
    // R5: bits 15:9 ignored, module 3, index 5
    hwrite(4, 16'hFE53);
    hwrite(5, 16'h0000);
    reg_mode = 1; dbg_en = 1; cmp_mask = 16'h0; cmp_data = 16'h1234;
    instr(4'd3, 5'd5, 16'h9999, 0);
    check("R6 dest-only match", {15'h0, brk_req}, 16'h1);
    cycle();
    check("R10 single pulse", {15'h0, brk_req}, 16'h0);
    instr(4'd3, 5'd5, 16'h0, 0);
    check("R10 no rearm without ack", {15'h0, brk_req}, 16'h0);
    ack();
    cmp_mask = 16'h00FF; cmp_data = 16'h0012;
    instr(4'd3, 5'd5, 16'hAB13, 0);
    check("R7 masked data mismatch", {15'h0, brk_req}, 16'h0);
    instr(4'd3, 5'd6, 16'hAB12, 0);
    check("R5 index mismatch", {15'h0, brk_req}, 16'h0);
    instr(4'd3, 5'd5, 16'hAB12, 0);
    check("R5 masked data match", {15'h0, brk_req}, 16'h1);
    ack();
    dbg_en = 0;
    instr(4'd3, 5'd5, 16'hAB12, 0);
    check("R4 disabled", {15'h0, brk_req}, 16'h0);
    dbg_en = 1;
    // R9 prefix hold
    instr(4'd3, 5'd5, 16'hAB12, 1);
    check("R9 held on prefix", {15'h0, brk_req}, 16'h0);
    cycle();
    check("R9 held while idle", {15'h0, brk_req}, 16'h0);
    instr(4'd0, 5'd1, 16'h0, 0);
    check("R9 release after prefixed op", {15'h0, brk_req}, 16'h1);
    ack();
    // R8 address role
    reg_mode = 0;
    instr(4'd3, 5'd5, 16'hAB12, 0);
    check("R8 reg write ignored", {15'h0, brk_req}, 16'h0);
    instr_done = 1; dmem_valid = 1; dmem_addr = 16'h0000; cycle(); idle();
    check("R8 address match bp5", {15'h0, brk_req}, 16'h1);
    ack();
    instr_done = 1; dmem_valid = 1; dmem_addr = 16'hFE52; cycle(); idle();
    check("R8 address mismatch", {15'h0, brk_req}, 16'h0);
    // R11 same-cycle write and compare
    reg_mode = 1; cmp_mask = 0;
    host_wr_en = 1; host_addr = 3'd4; host_wdata = 16'h0021;
    instr(4'd3, 5'd5, 16'h0, 0);
    check("R11 old value compared", {15'h0, brk_req}, 16'h1);
    ack();
    instr(4'd3, 5'd5, 16'h0, 0);
    check("R11 new value in force", {15'h0, brk_req}, 16'h0);
    // R2 test-logic-reset
    tlr_i = 1; host_wr_en = 1; host_addr = 3'd2; host_wdata = 16'h0;
    cycle(); idle();
    for (int a = 0; a < 6; a++) begin
      host_addr = 3'(a); #0.1;
      check("R2 preset", host_rdata, 16'hFFFF);
    end
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      dbg_en     = ($urandom % 10) != 0;
      if (($urandom % 50) == 0) reg_mode = ~reg_mode;
      tlr_i      = r == 0;
      host_wr_en = ($urandom % 8) == 0;
      host_addr  = 3'($urandom);
      host_wdata = {7'($urandom), 5'($urandom % 4), 4'($urandom % 4)};
      if (($urandom % 4) == 0) host_wdata = 16'($urandom);
      cmp_mask   = ($urandom % 2) ? 16'h0 : 16'($urandom);
      cmp_data   = 16'($urandom);
      instr_done = ($urandom % 3) != 0;
      wr_valid   = ($urandom % 4) != 0;
      wr_module  = 4'($urandom % 4);
      wr_index   = 5'($urandom % 4);
      wr_data    = ($urandom % 2) ? cmp_data ^ (16'($urandom) & ~cmp_mask) : 16'($urandom);
      dmem_valid = ($urandom % 2) != 0;
      dmem_addr  = ($urandom % 3 == 0) ? m_bp[4 + ($urandom % 2)] : 16'($urandom);
      pfx_active = ($urandom % 5) == 0;
      dbg_ack    = ($urandom % 4) == 0;
      cycle();
    end
    idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule